// File: doc/BRIEF.md
# Scalar Double-Precision Compare Unit

This unit compares the low 64-bit IEEE-754 double-precision element of a destination operand (A) with the low element of a source operand (B). An 8-bit immediate selects one of eight predicates. The unit writes the outcome as a 64-bit boolean mask into the low half of a 128-bit result. The high half of the result is a copy of the high half of the destination operand. A flag reports invalid-operation conditions, which depend on NaN operands and on the kind of predicate.

It is meant to sit in a vector execution lane behind decode and operand fetch. Each accepted request yields a registered result exactly one clock later. Requests may arrive back to back. The unit keeps no state other than its output registers.

Top module: `dcmp_scalar_unit`

## Requirements
- R1: Only bits [63:0] of each operand take part in the compare. Bits [127:64] of the source operand never affect any output.
- R2: The predicate is `pred_imm[2:0]` and bits [7:3] are ignored. The codes are: 0 A==B, 1 A<B, 2 A<=B, 3 unordered, 4 not equal, 5 not less-than, 6 not less-or-equal, 7 ordered.
- R3: A true predicate gives `res_data[63:0]` of all ones. A false predicate gives all zeros.
- R4: `res_data[127:64]` equals `dst_opnd[127:64]` of the same request.
- R5: A NaN is an operand whose exponent is all ones and whose mantissa is nonzero. If either operand is a NaN, the pair is unordered. Codes 0, 1, 2 and 7 are then false, and codes 3, 4, 5 and 6 are then true.
- R6: Positive zero and negative zero compare equal. Subnormal values are compared exactly and are never flushed to zero.
- R7: For ordered, unequal values, a negative value orders below a positive one. Two positive values are ordered by magnitude, and two negative values are ordered by magnitude reversed.
- R8: `res_invalid` is set when either operand is a NaN and the code is 1, 2, 5 or 6. For codes 0, 3, 4 and 7 it is set only when either operand is a signaling NaN, which is a NaN with mantissa bit 51 clear. In every other case it is clear.
- R9: `res_valid`, `res_data` and `res_invalid` appear exactly one clock after `in_valid`. `res_valid` is low in the clock after a cycle with no request, and it is low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| dst_opnd | input | 128 | Destination operand; the low element is A |
| src_opnd | input | 128 | Source operand; the low element is B |
| pred_imm | input | 8 | Immediate; bits [2:0] select the predicate |
| res_valid | output | 1 | Result strobe |
| res_data | output | 128 | High half passed through from A's register, low half holds the mask |
| res_invalid | output | 1 | Invalid-operation flag |

## Verification
The mask and the invalid flag can both be set in the same cycle. This happens, for example, when a NaN meets code 5 or 6: the mask is all ones and the flag is raised together. A signaling NaN under code 4 does the same. The bench provokes this with directed NaN operands swept over all eight codes, then with random operands drawn from pools of zeros, subnormals, infinities and quiet and signaling NaNs. A behavioural model built on real-number comparison judges the mask and the flag independently on every clock.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
  localparam int EXP_W   = 11;
  localparam int MAN_W   = 52;
  localparam int ELEM_W  = 1 + EXP_W + MAN_W;
  localparam int REG_W   = 2 * ELEM_W;
  localparam int IMM_W   = 8;
  localparam int PRED_W  = 3;
  localparam int NUM_OPS = 2;

  typedef enum logic [PRED_W-1:0] {
    P_EQ    = 3'd0,
    P_LT    = 3'd1,
    P_LE    = 3'd2,
    P_UNORD = 3'd3,
    P_NE    = 3'd4,
    P_NLT   = 3'd5,
    P_NLE   = 3'd6,
    P_ORD   = 3'd7
  } pred_e;

  typedef struct packed {
    logic              sign;
    logic [ELEM_W-2:0] mag;
    logic              is_nan;
    logic              is_snan;
    logic              is_zero;
  } fpcls_t;
endpackage

// File: rtl/dcmp_classify.sv
module dcmp_classify
  import dcmp_pkg::*;
(
  input  logic [ELEM_W-1:0] elem,
  output fpcls_t            cls
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;
  logic             man_nz;

  always_comb begin
    exp_f   = elem[ELEM_W-2 -: EXP_W];
    man_f   = elem[MAN_W-1:0];
    exp_max = &exp_f;
    man_nz  = |man_f;
    cls.sign    = elem[ELEM_W-1];
    cls.mag     = elem[ELEM_W-2:0];
    cls.is_nan  = exp_max & man_nz;
    cls.is_snan = exp_max & man_nz & ~man_f[MAN_W-1];
    cls.is_zero = ~|elem[ELEM_W-2:0];
  end
endmodule

// File: rtl/dcmp_relate.sv
module dcmp_relate
  import dcmp_pkg::*;
(
  input  fpcls_t op_a,
  input  fpcls_t op_b,
  output logic   unord,
  output logic   equal,
  output logic   less
);
  logic both_zero;
  logic mag_lt;
  logic mag_gt;

  always_comb begin
    unord     = op_a.is_nan | op_b.is_nan;
    both_zero = op_a.is_zero & op_b.is_zero;
    mag_lt    = op_a.mag < op_b.mag;
    mag_gt    = op_a.mag > op_b.mag;
    equal     = ~unord & (both_zero | ((op_a.sign == op_b.sign) && (op_a.mag == op_b.mag)));
    if (unord || both_zero) begin
      less = 1'b0;
    end else if (op_a.sign != op_b.sign) begin
      less = op_a.sign;
    end else if (op_a.sign) begin
      less = mag_gt;
    end else begin
      less = mag_lt;
    end
  end
endmodule

// File: rtl/dcmp_predicate.sv
module dcmp_predicate
  import dcmp_pkg::*;
(
  input  pred_e pred,
  input  logic  unord,
  input  logic  equal,
  input  logic  less,
  input  logic  any_snan,
  output logic  hit,
  output logic  invalid
);
  logic signalling_kind;

  always_comb begin
    unique case (pred)
      P_EQ:    hit = equal;
      P_LT:    hit = less;
      P_LE:    hit = less | equal;
      P_UNORD: hit = unord;
      P_NE:    hit = ~equal;
      P_NLT:   hit = ~less;
      P_NLE:   hit = ~(less | equal);
      default: hit = ~unord;
    endcase
    signalling_kind = (pred == P_LT) || (pred == P_LE) || (pred == P_NLT) || (pred == P_NLE);
    invalid         = signalling_kind ? unord : any_snan;
  end
endmodule

// File: rtl/dcmp_scalar_unit.sv
module dcmp_scalar_unit
  import dcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [REG_W-1:0] dst_opnd,
  input  logic [REG_W-1:0] src_opnd,
  input  logic [IMM_W-1:0] pred_imm,
  output logic             res_valid,
  output logic [REG_W-1:0] res_data,
  output logic             res_invalid
);
  localparam int HI_W = REG_W - ELEM_W;

  logic [ELEM_W-1:0] elems [NUM_OPS];
  fpcls_t            cls   [NUM_OPS];

  logic unord, equal, less, hit, invalid_c;
  logic unused_upper;

  logic             valid_d;
  logic [REG_W-1:0] data_d;
  logic             inv_d;

  assign elems[0]     = dst_opnd[ELEM_W-1:0];
  assign elems[1]     = src_opnd[ELEM_W-1:0];
  assign unused_upper = ^{src_opnd[REG_W-1:ELEM_W], pred_imm[IMM_W-1:PRED_W]};

  genvar gi;
  generate
    for (gi = 0; gi < NUM_OPS; gi++) begin : g_cls
      dcmp_classify u_cls (
        .elem (elems[gi]),
        .cls  (cls[gi])
      );
    end
  endgenerate

  dcmp_relate u_rel (
    .op_a  (cls[0]),
    .op_b  (cls[1]),
    .unord (unord),
    .equal (equal),
    .less  (less)
  );

  dcmp_predicate u_pred (
    .pred     (pred_e'(pred_imm[PRED_W-1:0])),
    .unord    (unord),
    .equal    (equal),
    .less     (less),
    .any_snan (cls[0].is_snan | cls[1].is_snan),
    .hit      (hit),
    .invalid  (invalid_c)
  );

  always_comb begin
    valid_d = in_valid;
    data_d  = {dst_opnd[REG_W-1 -: HI_W], {ELEM_W{hit}}};
    inv_d   = invalid_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
    end else begin
      res_valid <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      res_data    <= data_d;
      res_invalid <= inv_d;
    end
  end
endmodule

// File: rtl/dcmp_scalar_unit_chk.sv
module dcmp_scalar_unit_chk
  import dcmp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [REG_W-1:0] dst_opnd,
  input logic [REG_W-1:0] src_opnd,
  input logic [IMM_W-1:0] pred_imm,
  input logic             res_valid,
  input logic [REG_W-1:0] res_data,
  input logic             res_invalid
);
  logic a_nan, b_nan, any_nan, sig_pred;

  assign a_nan    = (&dst_opnd[62:52]) && (|dst_opnd[51:0]);
  assign b_nan    = (&src_opnd[62:52]) && (|src_opnd[51:0]);
  assign any_nan  = a_nan | b_nan;
  assign sig_pred = (pred_imm[1:0] == 2'b01) || (pred_imm[1:0] == 2'b10);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  a_r3_mask_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_data[63:0] == '0 || res_data[63:0] == '1));
  a_r4_upper_copy: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_data[127:64] == $past(dst_opnd[127:64]));
  a_r5_unord_true: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && any_nan && pred_imm[2:0] == 3'd3) |=> res_data[63:0] == '1);
  a_r5_ord_false: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && any_nan && pred_imm[2:0] == 3'd7) |=> res_data[63:0] == '0);
  a_r8_nan_signals: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && any_nan && sig_pred) |=> res_invalid);
  a_r8_ordered_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !any_nan) |=> !res_invalid);
endmodule

bind dcmp_scalar_unit dcmp_scalar_unit_chk u_chk (.*);

// File: tb/dcmp_scalar_unit_test.sv
module dcmp_scalar_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] dst_opnd, src_opnd;
  logic [7:0]   pred_imm;
  logic         res_valid;
  logic [127:0] res_data;
  logic         res_invalid;

  int nvec = 0;
  int nfail = 0;

  localparam logic [63:0] ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] TWO  = 64'h4000000000000000;
  localparam logic [63:0] MONE = 64'hBFF0000000000000;
  localparam logic [63:0] MTWO = 64'hC000000000000000;
  localparam logic [63:0] PZ   = 64'h0;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;

  always #4 clk = ~clk;

  dcmp_scalar_unit uut (.*);

  function automatic bit is_nan(logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction

  function automatic void ref_cmp(input logic [63:0] a, input logic [63:0] b,
                                  input logic [7:0] imm, output bit hit, output bit inv);
    real ra, rb;
    bit  un, sn;
    int  p;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    un = is_nan(a) || is_nan(b);
    sn = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
    p  = int'(imm) % 8;
    case (p)
      0: hit = !un && (ra == rb);
      1: hit = !un && (ra < rb);
      2: hit = !un && (ra <= rb);
      3: hit = un;
      4: hit = un || (ra != rb);
      5: hit = un || !(ra < rb);
      6: hit = un || !(ra <= rb);
      default: hit = !un;
    endcase
    inv = (p == 1 || p == 2 || p == 5 || p == 6) ? un : sn;
  endfunction

  task automatic check(input string tag, input bit ok, input logic [127:0] act, input logic [127:0] expv);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic step(input bit v, input logic [127:0] d, input logic [127:0] s,
                      input logic [7:0] imm, input string tag);
    bit h, iv;
    logic [127:0] ed;
    in_valid = v; dst_opnd = d; src_opnd = s; pred_imm = imm;
    ref_cmp(d[63:0], s[63:0], imm, h, iv);
    ed = {d[127:64], {64{h}}};
    @(negedge clk);
    check({tag, " R9 valid"}, res_valid === v, {127'd0, res_valid}, {127'd0, v});
    if (v) begin
      check({tag, " data"}, res_data === ed, res_data, ed);
      check({tag, " R8 invalid"}, res_invalid === iv, {127'd0, res_invalid}, {127'd0, iv});
    end
  endtask

  function automatic logic [63:0] rnd_op();
    logic [63:0] r;
    r = {$urandom, $urandom};
    case ($urandom % 8)
      0: return r;
      1: return {r[63], 63'd0};
      2: return {r[63], 11'd0, r[51:0]};
      3: return {r[63], 11'h7FF, 52'd0};
      4: return {r[63], 11'h7FF, 1'b1, r[50:0]};
      5: return {r[63], 11'h7FF, 1'b0, r[50:1], 1'b1};
      6: return {r[63], 11'h3FE + 11'(r[1:0]), 47'd0, r[8:4]};
      default: return {r[63], 11'h3FF, 49'd0, r[2:0]};
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; dst_opnd = '0; src_opnd = '0; pred_imm = '0;
    @(negedge clk); @(negedge clk);
    check("R9 reset", res_valid === 1'b0, {127'd0, res_valid}, 128'd0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R9 idle");

    step(1, {64'h0, PZ}, {64'h0, NZ}, 8'd0, "R6 zero eq");
    step(1, {64'h0, NZ}, {64'h0, PZ}, 8'd1, "R6 zero lt");
    step(1, {64'h0, 64'h1}, {64'h0, 64'h2}, 8'd1, "R6 subnormal lt");
    step(1, {64'h0, 64'h2}, {64'h0, 64'h1}, 8'd0, "R6 subnormal ne");
    step(1, {64'h0, MONE}, {64'h0, MTWO}, 8'd1, "R7 neg reversed");
    step(1, {64'h0, MTWO}, {64'h0, MONE}, 8'd1, "R7 neg lt");
    step(1, {64'h0, MONE}, {64'h0, ONE}, 8'd1, "R7 sign order");
    step(1, {64'h0, ONE}, {64'h0, TWO}, 8'd6, "R7 pos nle");
    step(1, {64'h0, PINF}, {64'h0, TWO}, 8'd6, "R7 inf nle");
    for (int p = 0; p < 8; p++) begin
      step(1, {64'h0, QNAN}, {64'h0, ONE}, 8'(p), "R5 qnan sweep");
      step(1, {64'h0, ONE}, {64'h0, SNAN}, 8'(p), "R8 snan sweep");
    end
    step(1, {64'h0, ONE}, {64'h0, ONE}, 8'hF9, "R2 high imm");
    step(1, {64'h0, ONE}, {64'h0, TWO}, 8'hF9, "R2 high imm lt");
    step(1, {64'h0, ONE}, {64'hFFFF_FFFF_FFFF_FFFF, ONE}, 8'd0, "R1 src high");
    step(1, {64'hDEAD_BEEF_0123_4567, TWO}, {64'h0, ONE}, 8'd5, "R4 upper R3 ones");
    step(1, {64'hCAFE_F00D_89AB_CDEF, ONE}, {64'h0, TWO}, 8'd5, "R4 upper R3 zeros");
    step(0, 0, 0, 0, "R9 gap");

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a, b;
      a = rnd_op();
      b = ($urandom % 6 == 0) ? a ^ {($urandom % 2 == 0), 63'd0} : rnd_op();
      step(($urandom % 5) != 0, {{$urandom, $urandom}, a}, {{$urandom, $urandom}, b},
           8'($urandom), "R5 R6 R7 R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule